// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Mode-Fault Detection

This block is a byte-wide SPI peripheral driven by a small register-mapped host port. It runs either as the bus master, generating the serial clock from the system clock and exchanging one byte per data-register write, or as a slave that shifts under a serial clock and select driven by another device. Every completed byte is moved from the shift register into a data register that the host reads. Only clock mode 0 is provided: the serial clock idles low, data is sampled on its rising edge and shifted on its falling edge, most significant bit first.

Two protection features are built in. If the slave-select input is pulled low while the block is the master, another master is assumed to be driving the bus. The block then drops out of master mode, disables itself, releases its clock and data outputs and latches a mode-fault flag. If a byte completes while the previous one is still unread, the old byte is kept and an overrun flag is raised, so no data is lost silently.

Host registers, at the address given by `reg_addr`: 0 is control (bit 0 enable, bit 1 master), 1 is status (bit 0 transfer done, bit 1 overrun, bit 2 mode fault), 2 is data. Reads return data combinationally and take effect at the clock edge where `reg_rd` is high.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register, the status register and the data register read 0, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: With control bits enable=1 and master=1, a data-register write starts an 8-bit exchange. `sck_o` idles low and has a period of 4 system clocks. `mosi_o` carries the written byte MSB first, changing on falling `sck_o` edges, and `miso_i` is sampled on rising edges. Exactly 8 rising edges occur per byte.
- R3: When a byte completes with the done flag (status bit 0) clear, the received byte is loaded into the data register and the done flag sets. A data-register read clears the done flag.
- R4: A data-register write while a master exchange is in progress is ignored: the byte on `mosi_o` is unchanged.
- R5: When a byte completes while the done flag is still set, the overrun flag (status bit 1) sets and the data register keeps its old byte. A data read alone does not clear the overrun flag; a status read that sees it set, followed by a data read, clears it.
- R6: While enable=1 and master=1, a low `ss_n_i` (after a two-flop synchronizer) clears both control bits, sets the mode-fault flag (status bit 2), drops `sck_oe` and `mosi_oe`, and aborts the exchange without setting the done flag.
- R7: After a mode fault the block stays disabled until the host writes the control register. A control-register write clears the mode-fault flag.
- R8: With enable=1, master=0 and `ss_n_i` low, the block drives `miso_oe` high. It presents the last written byte on `miso_o` MSB first and samples `mosi_i` on rising edges of the synchronized `sck_i`. After 8 falling edges the received byte completes as in R3.
- R9: With `ss_n_i` high in slave mode, `miso_oe` is low, `sck_i` edges have no effect and the bit counter returns to zero, so a partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears flags as defined) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_i | input | 1 | Active-low slave select / mode-fault sense |

## Verification
The bench aims at the fault taken in the middle of a master byte. A design that only set the flag would keep toggling the clock into a contended bus, or would raise the done flag for a byte that never finished. It checks that an overrun keeps the first byte and survives a lone data read. A design that overwrote, or cleared the flag on any read, would return the second byte or lose the overrun indication. A slave byte cut off by a select deassertion must be thrown away. A bit counter that was not reset would complete early and deliver a byte shifted by the partial bits.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MST_BIT  = 1;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_OVR_BIT  = 1;
  localparam int STAT_MODF_BIT = 2;
endpackage

// File: rtl/spi_mf_rstsync.sv
module spi_mf_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        hold_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        hold_q <= meta_q;
      end
    end
    assign sync_o[g] = hold_q;
  end
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              slave_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              miso_i,
  input  logic              sck_s,
  input  logic              ss_s,
  input  logic              mosi_s,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] DIV_HALF = CNT_W'(CLK_DIV / 2);
  localparam logic [CNT_W-1:0] DIV_RISE = CNT_W'(CLK_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CNT_W-1:0]  div_q, div_d;
  logic              busy_q, busy_d;
  logic              samp_q, samp_d;
  logic              sck_prev_q;
  logic              done_q, done_d;
  logic              slave_sel, s_rise, s_fall;

  assign slave_sel = slave_en & ~ss_s;
  assign s_rise    = sck_s & ~sck_prev_q;
  assign s_fall    = ~sck_s & sck_prev_q;

  always_comb begin
    sr_d   = sr_q;
    bit_d  = bit_q;
    div_d  = div_q;
    busy_d = busy_q;
    samp_d = samp_q;
    done_d = 1'b0;
    if (master_en) begin
      if (!busy_q) begin
        if (load) begin
          sr_d   = load_byte;
          busy_d = 1'b1;
          div_d  = '0;
          bit_d  = '0;
        end
      end else begin
        div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        if (div_q == DIV_RISE) samp_d = miso_i;
        if (div_q == DIV_LAST) begin
          sr_d = {sr_q[DATA_W-2:0], samp_q};
          if (bit_q == BIT_LAST) begin
            bit_d  = '0;
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
    end else if (slave_sel) begin
      busy_d = 1'b0;
      div_d  = '0;
      if (load && bit_q == '0 && !sck_s) sr_d = load_byte;
      if (s_rise) samp_d = mosi_s;
      if (s_fall) begin
        sr_d = {sr_q[DATA_W-2:0], samp_q};
        if (bit_q == BIT_LAST) begin
          bit_d  = '0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end else begin
      busy_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      if (slave_en && load) sr_d = load_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      bit_q      <= '0;
      div_q      <= '0;
      busy_q     <= 1'b0;
      samp_q     <= 1'b0;
      sck_prev_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      sr_q       <= sr_d;
      bit_q      <= bit_d;
      div_q      <= div_d;
      busy_q     <= busy_d;
      samp_q     <= samp_d;
      sck_prev_q <= sck_s;
      done_q     <= done_d;
    end
  end

  assign done    = done_q;
  assign rx_byte = sr_q;
  assign sck_o   = busy_q & (div_q >= DIV_HALF);
  assign mosi_o  = sr_q[DATA_W-1];
  assign miso_o  = sr_q[DATA_W-1];
  assign miso_oe = slave_sel;

  AST_START_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !busy_q && load) |=> (busy_q && !sck_o)); // R2
  AST_SS_HIGH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && !master_en && ss_s) |=> (bit_q == '0)); // R9
  AST_NO_SLAVE_DONE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && $past(ss_s) && ss_s) |-> !done_d); // R9
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ss_s,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx,
  output logic              master_en,
  output logic              slave_en,
  output logic              load
);
  logic              en_q, en_d, mst_q, mst_d;
  logic              done_q, done_d, ovr_q, ovr_d, modf_q, modf_d;
  logic              seen_q, seen_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              wr_ctrl, wr_data, rd_stat, rd_data, fault;

  assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);
  assign wr_data = reg_wr & (reg_addr == ADDR_DATA);
  assign rd_stat = reg_rd & (reg_addr == ADDR_STAT);
  assign rd_data = reg_rd & (reg_addr == ADDR_DATA);
  assign fault   = en_q & mst_q & ~ss_s;

  always_comb begin
    en_d   = en_q;
    mst_d  = mst_q;
    modf_d = modf_q;
    done_d = done_q;
    ovr_d  = ovr_q;
    seen_d = seen_q;
    data_d = data_q;
    if (wr_ctrl) begin
      en_d   = reg_wdata[CTRL_EN_BIT];
      mst_d  = reg_wdata[CTRL_MST_BIT];
      modf_d = 1'b0;
    end
    if (fault) begin
      en_d   = 1'b0;
      mst_d  = 1'b0;
      modf_d = 1'b1;
    end
    if (rd_stat && ovr_q) seen_d = 1'b1;
    if (rd_data) begin
      done_d = 1'b0;
      if (seen_q) begin
        ovr_d  = 1'b0;
        seen_d = 1'b0;
      end
    end
    if (eng_done) begin
      if (done_q && !rd_data) begin
        ovr_d = 1'b1;
      end else begin
        data_d = eng_rx;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      modf_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      seen_q <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      mst_q  <= mst_d;
      modf_q <= modf_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
      seen_q <= seen_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_EN_BIT]  = en_q;
        reg_rdata[CTRL_MST_BIT] = mst_q;
      end
      ADDR_STAT: begin
        reg_rdata[STAT_DONE_BIT] = done_q;
        reg_rdata[STAT_OVR_BIT]  = ovr_q;
        reg_rdata[STAT_MODF_BIT] = modf_q;
      end
      ADDR_DATA: reg_rdata = data_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign master_en = en_q & mst_q;
  assign slave_en  = en_q & ~mst_q;
  assign load      = wr_data;

  AST_MODF_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mst_q && !ss_s) |=> (!en_q && !mst_q && modf_q)); // R6
  AST_MODF_CLEARED_BY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !fault) |=> !modf_q); // R7
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && done_q && !rd_data) |=> (ovr_q && $stable(data_q))); // R5
  AST_DONE_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !eng_done) |=> !done_q); // R3
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  input  logic              ss_n_i
);
  localparam int PIN_SS   = 2;
  localparam int PIN_SCK  = 1;
  localparam int PIN_MOSI = 0;

  logic              rst_n_int;
  logic [2:0]        pins_s;
  logic              master_en, slave_en, load, eng_done;
  logic [DATA_W-1:0] eng_rx;

  spi_mf_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  spi_mf_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i ({ss_n_i, sck_i, mosi_i}),
    .sync_o  (pins_s)
  );

  spi_mf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ss_s      (pins_s[PIN_SS]),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .master_en (master_en),
    .slave_en  (slave_en),
    .load      (load)
  );

  spi_mf_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .master_en (master_en),
    .slave_en  (slave_en),
    .load      (load),
    .load_byte (reg_wdata),
    .miso_i    (miso_i),
    .sck_s     (pins_s[PIN_SCK]),
    .ss_s      (pins_s[PIN_SS]),
    .mosi_s    (pins_s[PIN_MOSI]),
    .done      (eng_done),
    .rx_byte   (eng_rx),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .miso_o    (miso_o),
    .miso_oe   (miso_oe)
  );

  assign sck_oe  = master_en;
  assign mosi_oe = master_en;
endmodule

// File: tb/spi_mf_ctrl_bench.sv
module spi_mf_ctrl_bench;
  logic       clk, rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sck_o, sck_oe, sck_i, mosi_o, mosi_oe, mosi_i;
  logic       miso_o, miso_oe, miso_i, ss_n_i;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] bm_shift, bm_rx;
  int bm_edges, last_rise, prev_rise;

  spi_mf_ctrl u_spi_mf_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  // external slave model for master-mode tests
  assign miso_i = bm_shift[7];
  always @(posedge sck_o) begin
    bm_rx     <= {bm_rx[6:0], mosi_o};
    bm_edges  <= bm_edges + 1;
    prev_rise <= last_rise;
    last_rise <= cyc;
  end
  always @(negedge sck_o) bm_shift <= {bm_shift[6:0], 1'b0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic slave_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_i = b[i];
      idle(8);
      got = {got[6:0], miso_o};
      sck_i = 1'b1;
      idle(8);
      sck_i = 1'b0;
      idle(8);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    reg_read(2'd0, v); check("R1 ctrl after reset", v, 8'h00);
    reg_read(2'd1, v); check("R1 status after reset", v, 8'h00);
    reg_read(2'd2, v); check("R1 data after reset", v, 8'h00);
    check("R1 output enables after reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);
  endtask

  task automatic t_master(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v;
    bm_shift = rx; bm_rx = '0; bm_edges = 0;
    reg_write(2'd2, tx);
    idle(40);
    check("R2 sck rising edge count", bm_edges, 8);
    check("R2 mosi byte seen by slave", bm_rx, tx);
    check("R2 sck period", last_rise - prev_rise, 4);
    check("R2 sck idles low", sck_o, 1'b0);
    reg_read(2'd1, v); check("R3 done flag set", v[0], 1'b1);
    reg_read(2'd2, v); check("R3 received byte", v, rx);
    reg_read(2'd1, v); check("R3 done cleared by data read", v[0], 1'b0);
  endtask

  task automatic t_busy_write;
    logic [7:0] v;
    bm_shift = 8'h96; bm_rx = '0; bm_edges = 0;
    reg_write(2'd2, 8'hA5);
    idle(10);
    reg_write(2'd2, 8'h3C);
    idle(40);
    check("R4 mid-transfer write ignored", bm_rx, 8'hA5);
    check("R4 single byte of clocks", bm_edges, 8);
    reg_read(2'd2, v); check("R4 received byte", v, 8'h96);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    bm_shift = 8'h11; reg_write(2'd2, 8'h01); idle(40);
    bm_shift = 8'h22; reg_write(2'd2, 8'h02); idle(40);
    reg_read(2'd2, v); check("R5 data keeps first byte", v, 8'h11);
    reg_read(2'd1, v); check("R5 overrun survives lone data read", v[1], 1'b1);
    reg_read(2'd2, v);
    reg_read(2'd1, v); check("R5 overrun cleared by status-then-data", v[1], 1'b0);
  endtask

  task automatic t_modefault;
    logic [7:0] v;
    bm_shift = 8'hFF; bm_edges = 0;
    check("R6 master drives sck before fault", sck_oe, 1'b1);
    reg_write(2'd2, 8'hF0);
    idle(8);
    ss_n_i = 1'b0;
    idle(6);
    check("R6 outputs released", {sck_oe, mosi_oe}, 2'b00);
    reg_read(2'd0, v); check("R6 control bits cleared", v[1:0], 2'b00);
    idle(40);
    reg_read(2'd1, v); check("R6 fault flag set, no done", v[2:0], 3'b100);
    check("R6 exchange aborted", bm_edges < 8, 1'b1);
    ss_n_i = 1'b1;
    idle(6);
    reg_read(2'd0, v); check("R7 stays disabled", v[1:0], 2'b00);
    check("R7 sck still released", sck_oe, 1'b0);
    reg_write(2'd0, 8'h03);
    reg_read(2'd1, v); check("R7 fault flag cleared by control write", v[2], 1'b0);
    check("R7 master re-enabled", sck_oe, 1'b1);
  endtask

  task automatic t_slave;
    logic [7:0] v, got;
    reg_write(2'd0, 8'h01);
    reg_write(2'd2, 8'hC3);
    idle(4);
    check("R9 miso released while deselected", miso_oe, 1'b0);
    ss_n_i = 1'b0; idle(4);
    check("R8 miso driven while selected", miso_oe, 1'b1);
    slave_bits(8'h6D, 8, got);
    idle(6);
    check("R8 slave sent loaded byte", got, 8'hC3);
    reg_read(2'd1, v); check("R8 slave done flag", v[0], 1'b1);
    reg_read(2'd2, v); check("R8 slave received byte", v, 8'h6D);
    ss_n_i = 1'b1; idle(4);
    check("R9 miso released after deselect", miso_oe, 1'b0);
    slave_bits(8'hFF, 8, got);
    idle(6);
    reg_read(2'd1, v); check("R9 sck ignored while deselected", v[0], 1'b0);
    ss_n_i = 1'b0; idle(4);
    slave_bits(8'hE0, 3, got);
    ss_n_i = 1'b1; idle(4);
    ss_n_i = 1'b0; idle(4);
    slave_bits(8'h5A, 8, got);
    idle(6);
    reg_read(2'd1, v); check("R9 partial byte discarded, one done", v[1:0], 2'b01);
    reg_read(2'd2, v); check("R9 full byte after reselect", v, 8'h5A);
    ss_n_i = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    bm_shift = '0; bm_rx = '0; bm_edges = 0; last_rise = 0; prev_rise = 0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    reg_write(2'd0, 8'h03);
    idle(2);
    t_master(8'hA7, 8'h5C);
    t_master(8'h01, 8'hFE);
    t_busy_write();
    t_overrun();
    t_modefault();
    t_master(8'h81, 8'h18);
    t_slave();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule